// File: doc/BRIEF.md
# Exception Priority and Entry Controller

This block sits beside a processor's register file and decides when the normal instruction stream must be left for a handler. Seven request lines are presented to it: a reset request, a data abort, a fast interrupt, a normal interrupt, a prefetch abort, an undefined-instruction trap and a software interrupt. Each cycle it masks the two interrupt lines with the current status word, ranks what is still pending, and picks one winner. Reset is acted on in whatever cycle it appears. Every other source is acted on only in a cycle where the surrounding pipeline reports that an instruction has finished.

When a source wins, the block issues the complete entry sequence as one set of write strobes: a new status word, a saved-status write and a link write both addressed to the handler's mode, and a forced program-counter load with that source's vector. It also executes an exception-return command, which copies the saved status back into the status word and loads the program counter in the same cycle. All write strobes are registered, so they appear in the cycle after the one in which the inputs were presented, and each lasts one cycle. The register storage and instruction fetch live outside the block; they simply obey the strobes.

Top module: `exc_ctrl`

## Requirements
- R1: Ranking from highest to lowest is reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, software interrupt; only the highest-ranked pending source is entered and all lower ones are ignored in that cycle.
- R2: The handler mode code is 0x13 (supervisor) for reset and software interrupt, 0x17 for both aborts, 0x11 for the fast interrupt, 0x12 for the normal interrupt and 0x1B for the undefined trap; it is driven on both the saved-status and link write mode outputs.
- R3: On entry the link write carries the next-instruction address and the saved-status write carries the status word as it was before entry.
- R4: On entry the new status word keeps bits 31:8 of the old word, sets bit 7 (normal interrupt mask), clears bit 5 (compact-instruction state), puts the handler mode in bits 4:0, and sets bit 6 (fast interrupt mask) for reset and the fast interrupt while keeping the old bit 6 for all other sources.
- R5: On entry the program counter is loaded with VEC_BASE plus the source's offset: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C.
- R6: A reset request is entered whether or not the instruction-boundary strobe is high; every other source is entered only in a cycle where that strobe is high.
- R7: The normal interrupt line has no effect while status bit 7 is 1, and the fast interrupt line has no effect while status bit 6 is 1; a lower-ranked pending source is entered instead.
- R8: A return command writes the saved status word into the status word and loads the return address into the program counter in the same cycle, with no link or saved-status write.
- R9: A return command takes precedence over every pending source except reset, with or without the boundary strobe; a reset request in the same cycle wins and the return is dropped.
- R10: All write strobes appear exactly one clock after the inputs that cause them and last one cycle; the block's own reset clears every strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block itself |
| req_reset | input | 1 | Reset exception request |
| req_dabt | input | 1 | Data abort request |
| req_fiq | input | 1 | Fast interrupt line, level-sensitive |
| req_irq | input | 1 | Normal interrupt line, level-sensitive |
| req_pabt | input | 1 | Prefetch abort request |
| req_swi | input | 1 | Software interrupt request |
| req_und | input | 1 | Undefined-instruction request |
| insn_end | input | 1 | High in a cycle where the current instruction completes |
| ret_req | input | 1 | Exception-return command |
| cur_psr | input | 32 | Current status word |
| saved_psr | input | 32 | Saved status word of the current mode, used by return |
| next_pc | input | AW | Address of the instruction after the current one |
| ret_pc | input | AW | Address to resume at on return |
| psr_we | output | 1 | Status word write strobe |
| psr_wdata | output | 32 | New status word |
| spsr_we | output | 1 | Saved-status write strobe |
| spsr_mode | output | 5 | Mode whose saved-status copy is written |
| spsr_wdata | output | 32 | Saved-status data |
| lr_we | output | 1 | Link write strobe |
| lr_mode | output | 5 | Mode whose link register is written |
| lr_wdata | output | AW | Link data |
| pc_we | output | 1 | Forced program-counter load strobe |
| pc_wdata | output | AW | Program-counter value to load |

## Verification
The hardest situation to reach is a cycle where a return command, a reset request, masked interrupt lines and several lower-ranked sources all coincide, since ordinary program flow never lines them up. The bench reaches it by sweeping every combination of the seven request lines, the boundary strobe, both mask bits and the return command, with status words and addresses derived from the sweep index so that each cycle's data is distinct. Between sweep steps it drops every input for a cycle and confirms that no strobe lingers.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int PSR_W   = 32;
    localparam int MODE_W  = 5;
    localparam int NUM_SRC = 7;
    localparam int SRC_W   = $clog2(NUM_SRC + 1);
    localparam int VOFF_W  = 5;

    // Handler mode codes
    typedef enum logic [MODE_W-1:0] {
        MODE_USER = 5'h10,
        MODE_FAST = 5'h11,
        MODE_INTR = 5'h12,
        MODE_SUPV = 5'h13,
        MODE_ABRT = 5'h17,
        MODE_UNDF = 5'h1B,
        MODE_SYST = 5'h1F
    } mode_e;

    // Source kinds; the numeric value is the rank (0 = highest)
    typedef enum logic [SRC_W-1:0] {
        EXK_RESET = 3'd0,
        EXK_DABT  = 3'd1,
        EXK_FIQ   = 3'd2,
        EXK_IRQ   = 3'd3,
        EXK_PABT  = 3'd4,
        EXK_UND   = 3'd5,
        EXK_SWI   = 3'd6,
        EXK_NONE  = 3'd7
    } exk_e;

    typedef struct packed {
        logic [3:0]  flags;
        logic [19:0] mid;
        logic        irq_off;
        logic        fiq_off;
        logic        thumb;
        logic [MODE_W-1:0] mode;
    } psr_t;

    function automatic logic [MODE_W-1:0] exk_mode(input exk_e k);
        logic [MODE_W-1:0] m;
        case (k)
            EXK_RESET: m = MODE_SUPV;
            EXK_SWI:   m = MODE_SUPV;
            EXK_DABT:  m = MODE_ABRT;
            EXK_PABT:  m = MODE_ABRT;
            EXK_FIQ:   m = MODE_FAST;
            EXK_IRQ:   m = MODE_INTR;
            EXK_UND:   m = MODE_UNDF;
            default:   m = MODE_SUPV;
        endcase
        return m;
    endfunction

    function automatic logic [VOFF_W-1:0] exk_vec_off(input exk_e k);
        logic [VOFF_W-1:0] o;
        case (k)
            EXK_RESET: o = 5'h00;
            EXK_UND:   o = 5'h04;
            EXK_SWI:   o = 5'h08;
            EXK_PABT:  o = 5'h0C;
            EXK_DABT:  o = 5'h10;
            EXK_IRQ:   o = 5'h18;
            EXK_FIQ:   o = 5'h1C;
            default:   o = 5'h00;
        endcase
        return o;
    endfunction

    function automatic logic exk_masks_fiq(input exk_e k);
        return (k == EXK_RESET) || (k == EXK_FIQ);
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
    parameter int N = 7
) (
    input  logic [N-1:0] pend,
    output logic [N-1:0] grant,
    output logic         any
);
    // blocked[i] is high when some source ranked above i is pending
    logic [N:0] blocked;

    assign blocked[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_rank
        assign grant[i]     = pend[i] & ~blocked[i];
        assign blocked[i+1] = blocked[i] | pend[i];
    end

    assign any = blocked[N];
endmodule

// File: rtl/exc_encoder.sv
module exc_encoder #(
    parameter int N = 7,
    parameter int W = 3
) (
    input  logic [N-1:0] onehot,
    input  logic         valid,
    output logic [W-1:0] idx
);
    always_comb begin
        idx = valid ? '0 : W'(N);
        for (int i = 0; i < N; i++) begin
            if (onehot[i]) idx = idx | W'(i);
        end
    end
endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
    import exc_pkg::*;
#(
    parameter int            AW       = 32,
    parameter logic [AW-1:0] VEC_BASE = '0
) (
    input  exk_e              kind,
    input  psr_t              cur,
    output psr_t              new_psr,
    output logic [MODE_W-1:0] bank_mode,
    output logic [AW-1:0]     vec
);
    always_comb begin
        bank_mode        = exk_mode(kind);
        new_psr          = cur;
        new_psr.mode     = bank_mode;
        new_psr.irq_off  = 1'b1;
        new_psr.thumb    = 1'b0;
        if (exk_masks_fiq(kind)) new_psr.fiq_off = 1'b1;
        vec = VEC_BASE + AW'(exk_vec_off(kind));
    end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
    import exc_pkg::*;
#(
    parameter int            AW       = 32,
    parameter logic [AW-1:0] VEC_BASE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_reset,
    input  logic              req_dabt,
    input  logic              req_fiq,
    input  logic              req_irq,
    input  logic              req_pabt,
    input  logic              req_swi,
    input  logic              req_und,
    input  logic              insn_end,
    input  logic              ret_req,
    input  logic [PSR_W-1:0]  cur_psr,
    input  logic [PSR_W-1:0]  saved_psr,
    input  logic [AW-1:0]     next_pc,
    input  logic [AW-1:0]     ret_pc,
    output logic              psr_we,
    output logic [PSR_W-1:0]  psr_wdata,
    output logic              spsr_we,
    output logic [MODE_W-1:0] spsr_mode,
    output logic [PSR_W-1:0]  spsr_wdata,
    output logic              lr_we,
    output logic [MODE_W-1:0] lr_mode,
    output logic [AW-1:0]     lr_wdata,
    output logic              pc_we,
    output logic [AW-1:0]     pc_wdata
);
    psr_t               cur;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] grant;
    logic               take;
    logic [SRC_W-1:0]   win_idx;
    exk_e               win;
    psr_t               entry_psr;
    logic [MODE_W-1:0]  entry_mode;
    logic [AW-1:0]      entry_vec;
    logic               gate;
    logic               do_ret;

    assign cur = psr_t'(cur_psr);

    // Non-reset sources wait for a boundary and yield to a return command
    assign gate = insn_end & ~ret_req;

    always_comb begin
        pend            = '0;
        pend[EXK_RESET] = req_reset;
        pend[EXK_DABT]  = gate & req_dabt;
        pend[EXK_FIQ]   = gate & req_fiq & ~cur.fiq_off;
        pend[EXK_IRQ]   = gate & req_irq & ~cur.irq_off;
        pend[EXK_PABT]  = gate & req_pabt;
        pend[EXK_UND]   = gate & req_und;
        pend[EXK_SWI]   = gate & req_swi;
    end

    exc_arbiter #(.N(NUM_SRC)) u_arb (
        .pend  (pend),
        .grant (grant),
        .any   (take)
    );

    exc_encoder #(.N(NUM_SRC), .W(SRC_W)) u_enc (
        .onehot (grant),
        .valid  (take),
        .idx    (win_idx)
    );

    assign win = exk_e'(win_idx);

    exc_entry_calc #(.AW(AW), .VEC_BASE(VEC_BASE)) u_calc (
        .kind      (win),
        .cur       (cur),
        .new_psr   (entry_psr),
        .bank_mode (entry_mode),
        .vec       (entry_vec)
    );

    assign do_ret = ret_req & ~req_reset;

    always_ff @(posedge clk) begin
        if (rst) begin
            psr_we     <= 1'b0;
            psr_wdata  <= '0;
            spsr_we    <= 1'b0;
            spsr_mode  <= '0;
            spsr_wdata <= '0;
            lr_we      <= 1'b0;
            lr_mode    <= '0;
            lr_wdata   <= '0;
            pc_we      <= 1'b0;
            pc_wdata   <= '0;
        end else begin
            psr_we  <= 1'b0;
            spsr_we <= 1'b0;
            lr_we   <= 1'b0;
            pc_we   <= 1'b0;
            if (take) begin
                psr_we     <= 1'b1;
                psr_wdata  <= PSR_W'(entry_psr);
                spsr_we    <= 1'b1;
                spsr_mode  <= entry_mode;
                spsr_wdata <= cur_psr;
                lr_we      <= 1'b1;
                lr_mode    <= entry_mode;
                lr_wdata   <= next_pc;
                pc_we      <= 1'b1;
                pc_wdata   <= entry_vec;
            end else if (do_ret) begin
                psr_we    <= 1'b1;
                psr_wdata <= saved_psr;
                pc_we     <= 1'b1;
                pc_wdata  <= ret_pc;
            end
        end
    end
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
    parameter int            AW       = 32,
    parameter logic [AW-1:0] VEC_BASE = '0
) (
    input logic          clk,
    input logic          rst,
    input logic          req_reset,
    input logic          insn_end,
    input logic          ret_req,
    input logic [31:0]   cur_psr,
    input logic [31:0]   saved_psr,
    input logic [AW-1:0] next_pc,
    input logic [AW-1:0] ret_pc,
    input logic          psr_we,
    input logic [31:0]   psr_wdata,
    input logic          spsr_we,
    input logic [4:0]    spsr_mode,
    input logic [31:0]   spsr_wdata,
    input logic          lr_we,
    input logic [4:0]    lr_mode,
    input logic [AW-1:0] lr_wdata,
    input logic          pc_we,
    input logic [AW-1:0] pc_wdata
);
    // High once the previous cycle was out of reset, so $past is meaningful
    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= !rst;

    a_r6_reset_immediate: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(req_reset) |-> (pc_we && lr_we && pc_wdata == VEC_BASE && lr_mode == 5'h13));

    a_r3_saved_copies: assert property (@(posedge clk) disable iff (rst || !armed)
        lr_we |-> (spsr_we && lr_wdata == $past(next_pc) && spsr_wdata == $past(cur_psr)
                   && spsr_mode == lr_mode));

    a_r4_entry_status: assert property (@(posedge clk) disable iff (rst || !armed)
        lr_we |-> (psr_wdata[7] && !psr_wdata[5] && psr_wdata[4:0] == lr_mode
                   && psr_wdata[31:8] == $past(cur_psr[31:8])));

    a_r6_needs_boundary: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(!req_reset && !insn_end && !ret_req) |-> (!pc_we && !psr_we && !lr_we));

    a_r8_atomic_return: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(ret_req && !req_reset) |-> (psr_we && pc_we && !lr_we && !spsr_we
            && psr_wdata == $past(saved_psr) && pc_wdata == $past(ret_pc)));

    a_r7_irq_gate: assert property (@(posedge clk) disable iff (rst || !armed)
        (lr_we && lr_mode == 5'h12) |-> !$past(cur_psr[7]));

    a_r7_fiq_gate: assert property (@(posedge clk) disable iff (rst || !armed)
        (lr_we && lr_mode == 5'h11) |-> !$past(cur_psr[6]));

    a_r10_strobes_paired: assert property (@(posedge clk) disable iff (rst)
        pc_we == psr_we);
endmodule

bind exc_ctrl exc_ctrl_chk #(.AW(AW), .VEC_BASE(VEC_BASE)) u_chk (.*);

// File: tb/tb_exc_ctrl.sv
module tb_exc_ctrl;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_reset = 0, req_dabt = 0, req_fiq = 0, req_irq = 0;
    logic          req_pabt = 0, req_swi = 0, req_und = 0;
    logic          insn_end = 0, ret_req = 0;
    logic [31:0]   cur_psr = '0, saved_psr = '0;
    logic [AW-1:0] next_pc = '0, ret_pc = '0;
    logic          psr_we, spsr_we, lr_we, pc_we;
    logic [31:0]   psr_wdata, spsr_wdata;
    logic [4:0]    spsr_mode, lr_mode;
    logic [AW-1:0] lr_wdata, pc_wdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    exc_ctrl #(.AW(AW)) dut (
        .clk(clk), .rst(rst),
        .req_reset(req_reset), .req_dabt(req_dabt), .req_fiq(req_fiq),
        .req_irq(req_irq), .req_pabt(req_pabt), .req_swi(req_swi),
        .req_und(req_und), .insn_end(insn_end), .ret_req(ret_req),
        .cur_psr(cur_psr), .saved_psr(saved_psr), .next_pc(next_pc),
        .ret_pc(ret_pc),
        .psr_we(psr_we), .psr_wdata(psr_wdata), .spsr_we(spsr_we),
        .spsr_mode(spsr_mode), .spsr_wdata(spsr_wdata), .lr_we(lr_we),
        .lr_mode(lr_mode), .lr_wdata(lr_wdata), .pc_we(pc_we),
        .pc_wdata(pc_wdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected model: rank index 0..6 = reset,dabt,fiq,irq,pabt,und,swi; 7 = none
    function automatic int pick(input logic [6:0] r, input bit ie, input bit ret,
                                input bit ioff, input bit foff);
        bit g;
        g = ie && !ret;
        if (r[0])               return 0;
        if (!g)                 return 7;
        if (r[1])               return 1;
        if (r[2] && !foff)      return 2;
        if (r[3] && !ioff)      return 3;
        if (r[4])               return 4;
        if (r[5])               return 5;
        if (r[6])               return 6;
        return 7;
    endfunction

    function automatic logic [4:0] mode_of(input int k);
        case (k)
            0, 6:    return 5'h13;
            1, 4:    return 5'h17;
            2:       return 5'h11;
            3:       return 5'h12;
            default: return 5'h1B;
        endcase
    endfunction

    function automatic logic [31:0] vec_of(input int k);
        case (k)
            0: return 32'h00;
            5: return 32'h04;
            6: return 32'h08;
            4: return 32'h0C;
            1: return 32'h10;
            3: return 32'h18;
            default: return 32'h1C;
        endcase
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10: block reset clears all strobes
        chk("R10 reset strobes", {28'd0, psr_we, spsr_we, lr_we, pc_we}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        for (int c = 0; c < 2048; c++) begin
            logic [6:0] r;
            bit ie, ioff, foff, ret, thumb;
            int k;
            string tag;
            logic [31:0] ep;
            r     = c[6:0];
            ie    = c[7];
            ioff  = c[8];
            foff  = c[9];
            ret   = c[10];
            thumb = c[0] ^ c[3];

            @(negedge clk);
            {req_swi, req_und, req_pabt, req_irq, req_fiq, req_dabt, req_reset} = r;
            insn_end  = ie;
            ret_req   = ret;
            cur_psr   = {4'(c >> 2), 20'(c * 37), ioff, foff, thumb, 5'h10 ^ 5'(c >> 4)};
            saved_psr = ~cur_psr ^ 32'(c);
            next_pc   = 32'h1000_0000 + 32'(c) * 4;
            ret_pc    = 32'h2000_0000 + 32'(c) * 8;

            k = pick(r, ie, ret, ioff, foff);
            if (r[0])                         tag = "R6 reset";
            else if (ret)                     tag = "R8 R9 return";
            else if (!ie)                     tag = "R6 boundary";
            else if ((r[2] && foff) || (r[3] && ioff)) tag = "R7 masked";
            else                              tag = "R1 rank";

            @(posedge clk);
            #1;
            if (k != 7) begin
                chk({tag, " strobes"}, {28'd0, psr_we, spsr_we, lr_we, pc_we}, 32'hF);
                chk("R5 vector", pc_wdata, vec_of(k));
                chk("R2 link mode", 32'(lr_mode), 32'(mode_of(k)));
                chk("R2 saved mode", 32'(spsr_mode), 32'(mode_of(k)));
                chk("R3 link data", lr_wdata, next_pc);
                chk("R3 saved data", spsr_wdata, cur_psr);
                ep = {cur_psr[31:8], 1'b1, (k == 0 || k == 2) ? 1'b1 : cur_psr[6], 1'b0, mode_of(k)};
                chk("R4 new status", psr_wdata, ep);
            end else if (ret) begin
                chk({tag, " strobes"}, {28'd0, psr_we, spsr_we, lr_we, pc_we}, 32'h9);
                chk("R8 status restore", psr_wdata, saved_psr);
                chk("R8 pc restore", pc_wdata, ret_pc);
            end else begin
                chk({tag, " no entry"}, {28'd0, psr_we, spsr_we, lr_we, pc_we}, 32'h0);
            end

            @(negedge clk);
            {req_swi, req_und, req_pabt, req_irq, req_fiq, req_dabt, req_reset} = '0;
            insn_end = 0;
            ret_req  = 0;
            @(posedge clk);
            #1;
            chk("R10 single pulse", {28'd0, psr_we, spsr_we, lr_we, pc_we}, 32'h0);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule